// File: doc/BRIEF.md
# Fractional-Prescaled Serial Baud Generator

This block derives the bit timing for a 16550-class serial port from a fixed 62.5 MHz reference clock. The reference passes through three stages in turn. First comes a fractional prescaler that divides by 1.000 to 63.875 in steps of one eighth. Next is the classic 16-bit integer divisor. Last is an oversampling counter with a ratio from 4 to 16. The bit rate is therefore reference / prescaler / divisor / oversampling. Two outputs come out of the block. `sample_tick` pulses once per oversampling slot, and `bit_tick` marks the slot that ends each bit period. Transmit and receive logic consume both.

Settings are written one byte at a time through a small write port. A whole setting can also be loaded at once from a packed 32-bit word. The prescaler is bypassed unless both the enhanced-mode bit and the prescaler-enable bit are set. This keeps software that only knows the classic divisor working at the usual rates.

A three-state sequencer supervises the counters:
- **HALT**: the counters are held clear and no ticks are produced.
- **SYNC**: a one-cycle clean start that follows any change of configuration.
- **RUN**: the counters advance.

The sequencer has four transitions:
- Any state moves to SYNC when the configuration changes.
- SYNC moves to RUN when the divisor is non-zero.
- SYNC moves to HALT when the divisor is zero.
- HALT and RUN stay where they are until the next configuration change.

Reset enters HALT.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset the divisor is 0 and both mode bits are clear, so no ticks appear. The stored oversampling field is 0, which selects a ratio of 16. The stored prescaler raw value is 271 (33.875). Setting both mode bits and a divisor of 1 therefore gives a bit tick every 542 reference cycles.
- R2: The prescaler holds a 9-bit raw value P in eighths. When it is active, the interval between successive sample ticks is floor or ceil of D*P/8 cycles, where D is the divisor. A bit tick comes every N*D*P/8 cycles whenever that number is an integer, where N is the oversampling ratio.
- R3: The prescaler divides by exactly 1 unless mode bit 0 (enhanced) and mode bit 1 (prescaler enable) are both set.
- R4: Oversampling field values 4 to 15 give that ratio. Values 0 to 3 give 16. A bit tick occurs on every N-th sample tick.
- R5: A prescaler raw value below 8 acts as 8 (divide by 1.0).
- R6: Any write to the prescaler low byte clears the prescaler high bit.
- R7: A divisor of 0 puts the sequencer in HALT, and no ticks are produced.
- R8: Loading a packed word sets four things at once:
  - bits 28:20 go to the prescaler raw value;
  - bits 19:16 go to the oversampling field;
  - bits 15:0 go to the divisor;
  - both mode bits are set.
- R9: A packed word whose bits 31:29 are not all zero is ignored, and the running timing is unaffected.
- R10: Every accepted configuration change passes through SYNC and clears all three counters. The first bit tick afterwards comes on exactly the N-th sample tick.
- R11: A bit tick is never produced without a sample tick in the same cycle.
- R12: The write port uses the following map. If a packed load and a byte write arrive in the same cycle, the packed load wins.

| Address | Contents |
|---|---|
| 0 | divisor low byte |
| 1 | divisor high byte |
| 2 | oversampling field, bits 3:0 |
| 3 | prescaler low byte |
| 4 | prescaler high bit, bit 0 |
| 5 | mode: bit 0 enhanced, bit 1 prescaler enable |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 62.5 MHz reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte register write strobe |
| wr_addr | input | 3 | Byte register address |
| wr_data | input | 8 | Byte register write data |
| cfg_load | input | 1 | Packed configuration load strobe |
| cfg_word | input | 32 | Packed configuration word |
| sample_tick | output | 1 | One pulse per oversampling slot |
| bit_tick | output | 1 | Pulse on the slot that ends a bit period |

## Verification
The timing chain is exercised with several kinds of setting, and each kind separates different faults:
- Integer prescaler settings give fixed sample spacing, which exposes off-by-one errors in the divisor and oversampling counters.
- A fractional prescaler (13/8) gives sample intervals that must alternate between two neighbouring lengths, which separates a correct accumulator from one that truncates or rounds.
- The reset prescaler of 271 combined with the oversampling ratio of 16 checks the reset values.
- Toggling each mode bit alone shows that the prescaler is bypassed.

Further stimuli cover the remaining rules:
- TCR values of 2 and 0 test the mapping onto 16.
- A raw prescaler of 3 tests the clamp to 8.
- A low-byte write after a high-bit packed load tests the clearing of the high bit.
- A packed word with a reserved bit set must leave the bit period unchanged.
- Zero divisors must leave both outputs silent.
- After each reconfiguration, the sample ticks before the first bit tick are counted to prove that the counters restarted cleanly.

// File: rtl/baud_pkg.sv
package baud_pkg;

    localparam int DIV_W   = 16;
    localparam int PRE_W   = 9;
    localparam int FRAC_W  = 3;
    localparam int TCR_W   = 4;
    localparam int OS_MIN  = 4;
    localparam int OS_MAX  = 16;
    localparam int OS_W    = $clog2(OS_MAX + 1);
    localparam int ADDR_W  = 3;
    localparam int DATA_W  = 8;
    localparam int CFG_W   = 32;
    localparam int PRE_LSB = DIV_W + TCR_W;
    localparam int RSV_LSB = PRE_LSB + PRE_W;
    localparam int PRE_ONE = 1 << FRAC_W;
    localparam logic [PRE_W-1:0] PRE_RESET = PRE_W'(271);

    typedef enum logic [1:0] {
        ST_HALT = 2'd0,
        ST_SYNC = 2'd1,
        ST_RUN  = 2'd2
    } gen_state_t;

    typedef enum logic [ADDR_W-1:0] {
        A_DIV_LO = 3'd0,
        A_DIV_HI = 3'd1,
        A_OS     = 3'd2,
        A_PRE_LO = 3'd3,
        A_PRE_HI = 3'd4,
        A_MODE   = 3'd5
    } reg_addr_t;

    function automatic logic [OS_W-1:0] os_ratio(input logic [TCR_W-1:0] field);
        if (int'(field) < OS_MIN)
            return OS_W'(OS_MAX);
        return OS_W'(field);
    endfunction

    function automatic logic [PRE_W-1:0] pre_step(input logic [PRE_W-1:0] raw,
                                                  input logic active);
        if (!active)
            return PRE_W'(PRE_ONE);
        if (int'(raw) < PRE_ONE)
            return PRE_W'(PRE_ONE);
        return raw;
    endfunction

endpackage

// File: rtl/baud_cfg_regs.sv
module baud_cfg_regs
    import baud_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cfg_load,
    input  logic [CFG_W-1:0]  cfg_word,
    output logic [DIV_W-1:0]  div_val,
    output logic [TCR_W-1:0]  os_field,
    output logic [PRE_W-1:0]  pre_raw,
    output logic              mode_enh,
    output logic              mode_pre,
    output logic              cfg_chg
);

    logic word_ok;
    assign word_ok = (cfg_word[CFG_W-1:RSV_LSB] == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_val  <= '0;
            os_field <= '0;
            pre_raw  <= PRE_RESET;
            mode_enh <= 1'b0;
            mode_pre <= 1'b0;
            cfg_chg  <= 1'b0;
        end else if (cfg_load) begin
            cfg_chg <= word_ok;
            if (word_ok) begin
                pre_raw  <= cfg_word[RSV_LSB-1:PRE_LSB];
                os_field <= cfg_word[PRE_LSB-1:DIV_W];
                div_val  <= cfg_word[DIV_W-1:0];
                mode_enh <= 1'b1;
                mode_pre <= 1'b1;
            end
        end else if (wr_en) begin
            cfg_chg <= 1'b1;
            case (wr_addr)
                A_DIV_LO: div_val[DATA_W-1:0]       <= wr_data;
                A_DIV_HI: div_val[DIV_W-1:DATA_W]   <= wr_data[DIV_W-DATA_W-1:0];
                A_OS:     os_field                  <= wr_data[TCR_W-1:0];
                A_PRE_LO: pre_raw                   <= {1'b0, wr_data[PRE_W-2:0]};
                A_PRE_HI: pre_raw[PRE_W-1]          <= wr_data[0];
                A_MODE: begin
                    mode_enh <= wr_data[0];
                    mode_pre <= wr_data[1];
                end
                default: cfg_chg <= 1'b0;
            endcase
        end else begin
            cfg_chg <= 1'b0;
        end
    end

    // R6
    cpr_clears_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !cfg_load && wr_addr == A_PRE_LO) |=> (pre_raw[PRE_W-1] == 1'b0));

    // R9
    bad_word_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_load && cfg_word[CFG_W-1:RSV_LSB] != '0)
            |=> ($stable(div_val) && $stable(pre_raw) && $stable(os_field) && !cfg_chg));

endmodule

// File: rtl/frac_prescaler.sv
module frac_prescaler #(
    parameter int PRE_W  = 9,
    parameter int FRAC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [PRE_W-1:0] p_step,
    output logic             pre_en
);

    localparam int ACC_W = PRE_W + 1;
    localparam logic [ACC_W-1:0] STEP = ACC_W'(1 << FRAC_W);

    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] acc_sum;
    logic [ACC_W-1:0] p_ext;

    always_comb begin
        p_ext   = {1'b0, p_step};
        acc_sum = acc + STEP;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            acc    <= '0;
            pre_en <= 1'b0;
        end else if (acc_sum >= p_ext) begin
            acc    <= acc_sum - p_ext;
            pre_en <= 1'b1;
        end else begin
            acc    <= acc_sum;
            pre_en <= 1'b0;
        end
    end

    // R2
    acc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |-> (acc < p_ext));

    // R5
    step_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        p_ext >= STEP);

endmodule

// File: rtl/int_divider.sv
module int_divider #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             in_en,
    input  logic [DIV_W-1:0] divisor,
    output logic             out_en
);

    logic [DIV_W-1:0] cnt;
    logic             last;

    assign last = (cnt == divisor - DIV_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt    <= '0;
            out_en <= 1'b0;
        end else if (in_en) begin
            cnt    <= last ? '0 : cnt + DIV_W'(1);
            out_en <= last;
        end else begin
            out_en <= 1'b0;
        end
    end

    // R7
    div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |-> (divisor != '0 && cnt < divisor));

endmodule

// File: rtl/os_counter.sv
module os_counter #(
    parameter int OS_W   = 5,
    parameter int OS_MIN = 4,
    parameter int OS_MAX = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            sample,
    input  logic [OS_W-1:0] ratio,
    output logic            bit_end
);

    logic [OS_W-1:0] cnt;
    logic            wrap;

    assign wrap    = (cnt == ratio - OS_W'(1));
    assign bit_end = sample && wrap;

    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            cnt <= '0;
        else if (sample)
            cnt <= wrap ? '0 : cnt + OS_W'(1);
    end

    // R4
    os_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |-> (cnt < ratio && int'(ratio) >= OS_MIN && int'(ratio) <= OS_MAX));

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
    import baud_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [2:0]  wr_addr,
    input  logic [7:0]  wr_data,
    input  logic        cfg_load,
    input  logic [31:0] cfg_word,
    output logic        sample_tick,
    output logic        bit_tick
);

    logic [DIV_W-1:0] div_val;
    logic [TCR_W-1:0] os_field;
    logic [PRE_W-1:0] pre_raw;
    logic             mode_enh;
    logic             mode_pre;
    logic             cfg_chg;
    logic [PRE_W-1:0] p_step;
    logic [OS_W-1:0]  ratio;
    logic             ctr_clear;
    logic             pre_en;
    logic             div_en;
    gen_state_t       state;
    gen_state_t       state_nx;

    baud_cfg_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .cfg_load (cfg_load),
        .cfg_word (cfg_word),
        .div_val  (div_val),
        .os_field (os_field),
        .pre_raw  (pre_raw),
        .mode_enh (mode_enh),
        .mode_pre (mode_pre),
        .cfg_chg  (cfg_chg)
    );

    assign p_step = pre_step(pre_raw, mode_enh && mode_pre);
    assign ratio  = os_ratio(os_field);

    always_comb begin
        state_nx = state;
        if (cfg_chg) begin
            state_nx = ST_SYNC;
        end else begin
            unique case (state)
                ST_HALT: state_nx = ST_HALT;
                ST_SYNC: state_nx = (div_val == '0) ? ST_HALT : ST_RUN;
                ST_RUN:  state_nx = ST_RUN;
                default: state_nx = ST_HALT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_HALT;
        else
            state <= state_nx;
    end

    always_comb begin
        unique case (state)
            ST_HALT: ctr_clear = 1'b1;
            ST_SYNC: ctr_clear = 1'b1;
            ST_RUN:  ctr_clear = cfg_chg;
            default: ctr_clear = 1'b1;
        endcase
    end

    frac_prescaler #(.PRE_W(PRE_W), .FRAC_W(FRAC_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (ctr_clear),
        .p_step (p_step),
        .pre_en (pre_en)
    );

    int_divider #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (ctr_clear),
        .in_en   (pre_en),
        .divisor (div_val),
        .out_en  (div_en)
    );

    os_counter #(.OS_W(OS_W), .OS_MIN(OS_MIN), .OS_MAX(OS_MAX)) u_os (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (ctr_clear),
        .sample  (div_en),
        .ratio   (ratio),
        .bit_end (bit_tick)
    );

    assign sample_tick = div_en;

    // R10
    restart_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_chg |=> (state == ST_SYNC));

    // R7
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT) |-> (!sample_tick && !bit_tick));

    // R11
    bit_with_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> sample_tick);

endmodule

// File: tb/frac_baud_gen_test.sv
`timescale 1ns/1ps
module frac_baud_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        cfg_load = 1'b0;
    logic [31:0] cfg_word = '0;
    logic        sample_tick;
    logic        bit_tick;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int wd = 0;

    int    exp_q[$];
    bit    armed = 0;
    bit    first_chk = 0;
    int    cur_n = 16;
    int    s_lo = 0;
    int    s_hi = 0;
    string cur_tag = "";

    int  last_s, last_b, scnt, stot;
    bit  have_s, have_b;

    frac_baud_gen uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .cfg_load    (cfg_load),
        .cfg_word    (cfg_word),
        .sample_tick (sample_tick),
        .bit_tick    (bit_tick)
    );

    always #2.5 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // monitor: pops expected bit periods and compares them with observed ticks
    always @(negedge clk) begin
        cyc++;
        if (!armed) begin
            have_s = 0;
            have_b = 0;
            scnt   = 0;
            stot   = 0;
        end else begin
            if (sample_tick) begin
                if (have_s && s_hi > 0)
                    check((cyc - last_s) >= s_lo && (cyc - last_s) <= s_hi,
                          {cur_tag, " R2 sample spacing"}, cyc - last_s, s_lo);
                last_s = cyc;
                have_s = 1;
                scnt++;
                stot++;
            end
            if (bit_tick) begin
                check(sample_tick, "R11 bit without sample", 0, 1);
                if (!have_b) begin
                    if (first_chk)
                        check(scnt == cur_n, {cur_tag, " R10 first bit sample count"}, scnt, cur_n);
                end else if (exp_q.size() > 0) begin
                    int e;
                    e = exp_q.pop_front();
                    check((cyc - last_b) == e, {cur_tag, " bit period"}, cyc - last_b, e);
                    check(scnt == cur_n, {cur_tag, " R4 samples per bit"}, scnt, cur_n);
                end
                last_b = cyc;
                have_b = 1;
                scnt   = 0;
            end
        end
    end

    task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic word_ld(input logic [31:0] w);
        @(posedge clk); #1;
        cfg_load = 1'b1; cfg_word = w;
        @(posedge clk); #1;
        cfg_load = 1'b0;
    endtask

    // driver: pushes expected bit periods, then waits for the monitor to drain them
    task automatic expect_run(input int n, input int bit_iv, input int lo, input int hi,
                              input int nbits, input bit fchk, input string tag);
        int t;
        repeat (2) @(posedge clk);
        #1;
        cur_n = n; s_lo = lo; s_hi = hi; cur_tag = tag; first_chk = fchk;
        for (int i = 0; i < nbits; i++) exp_q.push_back(bit_iv);
        armed = 1;
        t = 0;
        while (exp_q.size() != 0 && t < bit_iv * (nbits + 3) + 200) begin
            @(posedge clk);
            t++;
        end
        #1;
        if (exp_q.size() != 0) begin
            check(0, {tag, " bit ticks missing"}, nbits - exp_q.size(), nbits);
            exp_q.delete();
        end
        armed = 0;
    endtask

    task automatic expect_quiet(input int cycles, input string tag);
        repeat (2) @(posedge clk);
        #1;
        armed = 1;
        repeat (cycles) @(posedge clk);
        #1;
        check(stot == 0, {tag, " ticks while silent"}, stot, 0);
        armed = 0;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        check(sample_tick == 1'b0 && bit_tick == 1'b0, "R1 reset outputs", int'(sample_tick), 0);

        // R1: silent after reset, then default prescaler 271 and ratio 16
        expect_quiet(500, "R1");
        reg_wr(3'd5, 8'h03);
        reg_wr(3'd0, 8'h01);
        expect_run(16, 542, 33, 34, 3, 1, "R1");

        // R3: prescaler bypassed with only one mode bit set
        reg_wr(3'd5, 8'h01);
        reg_wr(3'd0, 8'h05);
        expect_run(16, 80, 5, 5, 3, 1, "R3 enh-only");
        reg_wr(3'd5, 8'h02);
        expect_run(16, 80, 5, 5, 3, 1, "R3 pre-only");

        // R4: oversampling ratios
        reg_wr(3'd5, 8'h00);
        reg_wr(3'd0, 8'h03);
        reg_wr(3'd2, 8'h04);
        expect_run(4, 12, 3, 3, 3, 1, "R4 tcr4");
        reg_wr(3'd2, 8'h0F);
        expect_run(15, 45, 3, 3, 3, 1, "R4 tcr15");
        reg_wr(3'd2, 8'h02);
        expect_run(16, 48, 3, 3, 3, 1, "R4 tcr2");
        reg_wr(3'd2, 8'h00);
        expect_run(16, 48, 3, 3, 2, 1, "R4 tcr0");

        // R2: fractional prescaler 13/8
        reg_wr(3'd5, 8'h03);
        reg_wr(3'd3, 8'd13);
        reg_wr(3'd0, 8'h02);
        reg_wr(3'd2, 8'h08);
        expect_run(8, 26, 3, 4, 4, 1, "R2 frac");

        // R5: raw value below 8 clamps to 8
        reg_wr(3'd3, 8'd3);
        reg_wr(3'd2, 8'h04);
        expect_run(4, 8, 2, 2, 4, 1, "R5 clamp");

        // R8: packed load sets fields and both mode bits
        reg_wr(3'd5, 8'h00);
        word_ld(32'h0145_0004);
        expect_run(5, 50, 10, 10, 3, 1, "R8 word");
        word_ld(32'h1F44_0001);
        expect_run(4, 250, 62, 63, 3, 1, "R8 hiword");

        // R6: low-byte write clears the high bit (64, not 320)
        reg_wr(3'd3, 8'h40);
        expect_run(4, 32, 8, 8, 3, 1, "R6 cpr");

        // R9: reserved bits set, word ignored
        word_ld(32'h2145_0004);
        expect_run(4, 32, 8, 8, 3, 0, "R9 ignored");

        // R7: zero divisor halts
        reg_wr(3'd0, 8'h00);
        expect_quiet(3000, "R7");

        // R12: divisor high byte
        reg_wr(3'd5, 8'h00);
        reg_wr(3'd2, 8'h04);
        reg_wr(3'd1, 8'h01);
        expect_run(4, 1024, 256, 256, 2, 1, "R12 dlm");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule